// File: doc/BRIEF.md
# ADC Conversion Cycle Sequencer

This block is the control core of a low-power converter that loops through three phases: measuring, idling in a power-down state with the finished result held, and serving that result over a simplified serial byte link. After reset it starts a measurement of fixed length, counted on the internal oscillator clock. When the count runs out it captures the 16-bit result word from the filter, which is modelled as an input port, and powers the converter down. If sleep has been selected, it also powers down the reference.

In the power-down state it waits for a bus request. The request is acknowledged and the block enters the transfer state. In that state the host can write a configuration byte that picks nap or sleep, and can pull result bits one at a time, MSB first. The next measurement starts after the sixteenth bit is read or when the host ends the transaction with a stop. A running measurement never yields to bus traffic: requests during it are refused with a NACK. Only the synchronous power-on reset restarts it.

Top module: `adc_cycle_seq`

## Requirements
- R1: While `rst` is high and after it is released, `converting` is 1, both power-down outputs are 0, and `bus_ack`, `bus_nack` and `sdo_valid` are 0.
- R2: A measurement occupies exactly `CONV_CYCLES` clock cycles, counted from the cycle in which it starts. It then ends with no condition and the block enters the power-down state (`converting` goes to 0).
- R3: A `bus_req` during a measurement gives a one-cycle `bus_nack` on the next cycle and no `bus_ack`. The measurement length is unchanged.
- R4: In the power-down state `converter_pd` is 1. `reference_pd` is 1 only when sleep mode is selected. Both are 0 while converting.
- R5: The result word is captured on the final measurement cycle. Later changes of `result_in` do not alter the value that is served.
- R6: A `bus_req` in the power-down state gives a one-cycle `bus_ack` on the next cycle, with no `bus_nack`, and the block moves to the transfer state.
- R7: Each `bit_req` in the transfer state produces `sdo_valid` on the next cycle, with `sdo` carrying the next held bit, starting at bit 15 and going down to bit 0.
- R8: On the cycle after the sixteenth bit is served, `converting` is 1 and a new full-length measurement has begun.
- R9: A `bus_stop` in the transfer state starts a new measurement on the next cycle. The next transfer starts again from bit 15.
- R10: A `cfg_wr` in the transfer state sets sleep mode from `cfg_data` bit 0 (1 = sleep, 0 = nap), ignores the other bits, and updates `reference_pd` on the next cycle. Outside the transfer state `cfg_wr` is ignored. Reset selects nap.
- R11: `bit_req` outside the transfer state gives no `sdo_valid`. `bus_req` inside the transfer state gives neither `bus_ack` nor `bus_nack`.
- R12: Raising `rst` at any point forces the measuring state with the timer restarted, so the following measurement is full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| result_in | input | RES_W | Filter output word, sampled at the end of a measurement |
| bus_req | input | 1 | Addressed bus transaction request, one-cycle pulse |
| bus_stop | input | 1 | Stop condition ending the transaction |
| bit_req | input | 1 | Request for the next result bit |
| cfg_wr | input | 1 | Configuration byte strobe |
| cfg_data | input | CFG_W | Configuration byte, bit 0 selects sleep |
| bus_ack | output | 1 | Request accepted |
| bus_nack | output | 1 | Request refused during a measurement |
| sdo | output | 1 | Served result bit |
| sdo_valid | output | 1 | `sdo` holds a new bit |
| converting | output | 1 | Measuring state active |
| converter_pd | output | 1 | Converter powered down |
| reference_pd | output | 1 | Reference powered down |

## Verification
The bench measures the length of every measurement: after reset, after a full read, after a stop, and after a reset in mid-measurement. It also fires a bus request into a running measurement. A design that aborted or stretched on that request, or whose timer was off by one, would report the wrong cycle count. The result input is changed right after capture, so a holding register that tracked its input would serve the wrong word. A partial read is cut short by a stop and then followed by a full read, which exposes a bit pointer that is not cleared. Configuration writes are made outside the transfer state and with every bit set except bit 0, so a design that decoded the wrong field or took writes at any time would show the wrong `reference_pd`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_CONV = 2'd0,
    ST_NAP  = 2'd1,
    ST_XFER = 2'd2
  } seq_state_t;
endpackage

// File: rtl/seq_conv_timer.sv
module seq_conv_timer #(
  parameter int CYCLES = 16600
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (done) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: the count never passes its terminal value
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/seq_result_reg.sv
module seq_result_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         active,
  input  logic         shift_en,
  output logic         last,
  output logic         sdo,
  output logic         sdo_valid,
  output logic [W-1:0] hold
);
  localparam int PW = (W > 1) ? $clog2(W) : 1;
  localparam logic [PW-1:0] TOP = PW'(W - 1);

  logic [PW-1:0] ptr;

  assign last = shift_en && (ptr == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
    end else if (load) begin
      hold <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      ptr <= '0;
    end else if (shift_en) begin
      ptr <= last ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo       <= 1'b0;
      sdo_valid <= 1'b0;
    end else begin
      sdo_valid <= shift_en;
      if (shift_en) begin
        sdo <= hold[TOP - ptr];
      end
    end
  end

  // R7: a served bit always answers a request of the previous cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    sdo_valid |-> $past(shift_en));
  // R8: serving the final bit returns the pointer to the top
  a_r8_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
    last |=> (ptr == '0));
endmodule

// File: rtl/adc_cycle_seq.sv
module adc_cycle_seq
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 16600,
  parameter int RES_W       = 16,
  parameter int CFG_W       = 8,
  parameter int SLEEP_BIT   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RES_W-1:0] result_in,
  input  logic             bus_req,
  input  logic             bus_stop,
  input  logic             bit_req,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  output logic             bus_ack,
  output logic             bus_nack,
  output logic             sdo,
  output logic             sdo_valid,
  output logic             converting,
  output logic             converter_pd,
  output logic             reference_pd
);
  seq_state_t       state, nxt;
  logic             tmr_done;
  logic             last_bit;
  logic             sleep_q, sleep_nxt;
  logic [RES_W-1:0] hold_w;

  seq_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (state == ST_CONV),
    .done (tmr_done)
  );

  seq_result_reg #(.W(RES_W)) u_result (
    .clk       (clk),
    .rst       (rst),
    .load      (tmr_done),
    .din       (result_in),
    .active    (state == ST_XFER),
    .shift_en  (bit_req && (state == ST_XFER)),
    .last      (last_bit),
    .sdo       (sdo),
    .sdo_valid (sdo_valid),
    .hold      (hold_w)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_CONV: if (tmr_done) nxt = ST_NAP;
      ST_NAP:  if (bus_req) nxt = ST_XFER;
      ST_XFER: if (bus_stop || last_bit) nxt = ST_CONV;
      default: nxt = ST_CONV;
    endcase
  end

  assign sleep_nxt = (state == ST_XFER && cfg_wr) ? cfg_data[SLEEP_BIT] : sleep_q;
  assign converting = (state == ST_CONV);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_CONV;
      sleep_q      <= 1'b0;
      bus_ack      <= 1'b0;
      bus_nack     <= 1'b0;
      converter_pd <= 1'b0;
      reference_pd <= 1'b0;
    end else begin
      state        <= nxt;
      sleep_q      <= sleep_nxt;
      bus_ack      <= bus_req && (state == ST_NAP);
      bus_nack     <= bus_req && (state == ST_CONV);
      converter_pd <= (nxt != ST_CONV);
      reference_pd <= (nxt != ST_CONV) && sleep_nxt;
    end
  end

  // R3: a running measurement only leaves on timer expiry
  a_r3_no_abort: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && !tmr_done) |=> (state == ST_CONV));
  // R4: nothing is powered down while measuring
  a_r4_pd_off_conv: assert property (@(posedge clk) disable iff (rst)
    converting |-> (!converter_pd && !reference_pd));
  // R5: held word is static outside the measuring state
  a_r5_hold_static: assert property (@(posedge clk) disable iff (rst)
    (state != ST_CONV) |=> $stable(hold_w));
  // R6: accept and refuse never coincide, and an accept lands in transfer
  a_r6_ack_excl: assert property (@(posedge clk) disable iff (rst)
    !(bus_ack && bus_nack));
  a_r6_ack_xfer: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> (state == ST_XFER));
endmodule

// File: tb/adc_cycle_seq_test.sv
module adc_cycle_seq_test;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] result_in = '0;
  logic        bus_req = 0, bus_stop = 0, bit_req = 0, cfg_wr = 0;
  logic [7:0]  cfg_data = '0;
  logic        bus_ack, bus_nack, sdo, sdo_valid, converting, converter_pd, reference_pd;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit exp_q[$];

  always #2 clk = ~clk;

  adc_cycle_seq #(.CONV_CYCLES(N)) uut (
    .clk(clk), .rst(rst), .result_in(result_in), .bus_req(bus_req),
    .bus_stop(bus_stop), .bit_req(bit_req), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .bus_ack(bus_ack), .bus_nack(bus_nack), .sdo(sdo), .sdo_valid(sdo_valid),
    .converting(converting), .converter_pd(converter_pd), .reference_pd(reference_pd)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each served bit with the queued expectation (R7)
  always @(negedge clk) begin
    if (sdo_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected bit actual=%0d expected=none", sdo);
      end else begin
        automatic bit e = exp_q.pop_front();
        if (sdo !== e) begin
          errors++;
          $display("FAIL R7 served bit actual=%0d expected=%0d", sdo, e);
        end
      end
    end
  end

  // samples after the start cycle while converting; a full measurement gives N-1
  task automatic measure_conv(input bit poke, output int n);
    n = 0;
    for (int i = 0; i < 4 * N; i++) begin
      @(negedge clk);
      bus_req = poke && (i == 2);
      if (poke && i == 3) begin
        chk("R3 nack on request during measurement", bus_nack, 1);
        chk("R3 no ack during measurement", bus_ack, 0);
      end
      if (!converting) break;
      n++;
    end
    bus_req = 0;
  endtask

  // driver: requests n bits and pushes the expected ones, MSB first
  task automatic read_bits(input int n, input logic [15:0] word);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_req = 1;
      exp_q.push_back(word[15 - i]);
    end
    @(negedge clk);
    bit_req = 0;
  endtask

  task automatic request;
    @(negedge clk); bus_req = 1;
    @(negedge clk); bus_req = 0;
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1; cfg_data = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic stop_xfer;
    @(negedge clk); bus_stop = 1;
    @(negedge clk); bus_stop = 0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 converting in reset", converting, 1);
    chk("R1 converter_pd in reset", converter_pd, 0);
    chk("R1 reference_pd in reset", reference_pd, 0);
    chk("R1 ack/nack/valid in reset", bus_ack | bus_nack | sdo_valid, 0);
    result_in = 16'hA5C3;
    rst = 0;
    measure_conv(1, n);
    chk("R3 length unchanged by refused request", n, N - 1);
    chk("R4 converter_pd in nap", converter_pd, 1);
    chk("R4 reference_pd in nap", reference_pd, 0);
    result_in = 16'h1234;                    // R5: must not be served
    @(negedge clk); bit_req = 1;
    @(negedge clk); bit_req = 0;
    chk("R11 bit_req outside transfer", sdo_valid, 0);
    write_cfg(8'h01);
    chk("R10 cfg write outside transfer ignored", reference_pd, 0);
    request();
    chk("R6 ack", bus_ack, 1);
    chk("R6 no nack", bus_nack, 0);
    chk("R6 left measuring", converting, 0);
    request();
    chk("R11 request in transfer ignored", bus_ack | bus_nack, 0);
    read_bits(16, 16'hA5C3);                 // R5 held word, R7 order
    chk("R8 restart after 16 bits", converting, 1);
    result_in = 16'h8001;
    measure_conv(0, n);
    chk("R2 measurement length", n, N - 1);
    request();
    write_cfg(8'h01);
    chk("R10 sleep selects reference_pd", reference_pd, 1);
    read_bits(5, 16'h8001);
    stop_xfer();
    chk("R9 stop restarts measuring", converting, 1);
    chk("R4 pd released while measuring", converter_pd | reference_pd, 0);
    result_in = 16'h6E19;
    measure_conv(0, n);
    chk("R9 measurement length after stop", n, N - 1);
    chk("R4 converter_pd in sleep", converter_pd, 1);
    chk("R4 reference_pd in sleep", reference_pd, 1);
    request();
    read_bits(16, 16'h6E19);                 // R9 restarts at bit 15
    chk("R8 restart after full read", converting, 1);
    result_in = 16'h0F0F;
    measure_conv(0, n);
    chk("R8 measurement length after read", n, N - 1);
    request();
    write_cfg(8'hFE);
    chk("R10 only bit 0 decoded", reference_pd, 0);
    stop_xfer();
    repeat (7) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R12 reset forces measuring", converting, 1);
    chk("R12 reset releases pd", converter_pd | reference_pd, 0);
    rst = 0;
    measure_conv(0, n);
    chk("R12 full length after reset", n, N - 1);
    request();
    read_bits(16, 16'h0F0F);
    @(negedge clk);
    chk("R7 all queued bits served", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule